// File: doc/BRIEF.md
# UART Modem-Line Flow Controller

This block sits beside a UART's receive FIFO and transmitter and drives the modem handshake pins on its own. It compares the receive FIFO fill level against an upper and a lower threshold. It keeps a "receiver nearly full" state with hysteresis. From that state it can drive the active-low request-to-send pin, the data-terminal-ready pin, or both. When no automatic mode is selected for a pin, the pin follows a software modem control bit.

In the transmit direction the block watches the active-low clear-to-send and data-set-ready inputs. It first passes them through a flip-flop synchronizer. When automatic gating is enabled and the synchronized input shows the far end as not ready, the transmit-permit output is withdrawn. It changes only while the serializer reports that it is between characters, so a character already in progress is always finished.

For half-duplex RS485 links, the data-terminal-ready pin can instead carry a driver-enable. The pin is held active (low) while the transmitter is not empty, and it is released only once the last stop bit has left the shift register. The threshold values are held outside the block, where software can read them back. The FIFO level input covers 0 to 128 entries.

Top module: `uart_mflow_ctrl`

## Requirements
- R1: Synchronous active-low reset. During reset and on the first cycle after it, `rts_n` and `dtr_n` are 1 (deasserted) and `tx_permit` is 1.
- R2: The nearly-full state sets on the first clock edge at which `rx_level >= thr_hi`. With `auto_rts_en` set, `rts_n` then reads 1 after that edge.
- R3: With `rx_level < thr_lo` and `rx_level < thr_hi`, the nearly-full state clears on the next edge. With `auto_rts_en` set, `rts_n` then reads 0.
- R4: While `thr_lo <= rx_level < thr_hi`, the nearly-full state, and so `rts_n` under automatic control, keeps its previous value.
- R5: With `auto_dtr_en` set and `rs485_en` clear, `dtr_n` follows the same nearly-full state as R2 to R4 (1 = full). This is independent of `auto_rts_en`.
- R6: With `rs485_en` set, `dtr_n` equals `tx_empty` one edge later (0 = drive bus while data remains). This takes priority over `auto_dtr_en` and `sw_dtr`.
- R7: With its automatic mode off, `rts_n` becomes `~sw_rts` one edge later. With `auto_dtr_en` and `rs485_en` both off, `dtr_n` becomes `~sw_dtr` one edge later. Software bits are active-high.
- R8: With `auto_cts_en` set, a synchronized `cts_n` of 1 clears `tx_permit`, and a synchronized `cts_n` of 0 sets it. `tx_permit` changes only on edges where `tx_idle` is 1 and holds while `tx_idle` is 0.
- R9: With `auto_dsr_en` set, `dsr_n` gates `tx_permit` the same way as `cts_n` does in R8.
- R10: `cts_n` and `dsr_n` pass through two flip-flops (reset to 1). A change applied before edge 1 first affects `tx_permit` at edge 3 when `tx_idle` is 1.
- R11: With `auto_cts_en` and `auto_dsr_en` both clear, `cts_n` and `dsr_n` have no effect: `tx_permit` is 1 after each idle edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | 8 | Receive FIFO fill level, 0 to 128 |
| thr_hi | input | 8 | Upper threshold (set nearly-full) |
| thr_lo | input | 8 | Lower threshold (clear nearly-full) |
| auto_rts_en | input | 1 | Automatic control of rts_n |
| auto_dtr_en | input | 1 | Automatic threshold control of dtr_n |
| auto_cts_en | input | 1 | Gate transmitter on cts_n |
| auto_dsr_en | input | 1 | Gate transmitter on dsr_n |
| rs485_en | input | 1 | dtr_n becomes RS485 driver-enable |
| sw_rts | input | 1 | Software request-to-send, active high |
| sw_dtr | input | 1 | Software terminal-ready, active high |
| cts_n | input | 1 | Clear-to-send pin, asynchronous, active low |
| dsr_n | input | 1 | Data-set-ready pin, asynchronous, active low |
| tx_idle | input | 1 | Serializer is between characters |
| tx_empty | input | 1 | Holding and shift registers empty, last stop bit sent |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready / driver-enable pin, active low |
| tx_permit | output | 1 | Transmitter may start a new character |

## Verification
The pin outputs are registered, so a change in level, threshold, software bit or `tx_empty` shows on `rts_n`/`dtr_n` after one rising edge. The bench drives on the falling edge and samples on the next falling edge. `tx_permit` reacts to the modem inputs on the third rising edge, two synchronizer stages plus the permit register. The bench therefore checks that the old value still holds after two edges and that the new value appears after the third. Character-boundary holding is checked by keeping `tx_idle` low for several edges after the input change and sampling before releasing it.

// File: rtl/mflow_pkg.sv
// Package: shared widths and the mode bundle for the modem flow controller.
// Assumes a receive FIFO of at most 2**LVL_W - 1 entries.
package mflow_pkg;
    localparam int unsigned FIFO_DEPTH = 128;
    localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic auto_rts;
        logic auto_dtr;
        logic auto_cts;
        logic auto_dsr;
        logic rs485;
    } mflow_mode_t;
endpackage

// File: rtl/mflow_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent (no multi-bit coherence needed).
module mflow_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/mflow_hyst.sv
// Module: receive-level hysteresis. Sets a nearly-full flag at or above the
// upper threshold, clears it below the lower one, holds it in between.
// Assumes thr_lo <= thr_hi; if not, setting wins.
module mflow_hyst #(
    parameter int unsigned LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    output logic             full_nxt,
    output logic             full_q
);
    logic at_hi, below_lo;

    // Compare the level against both thresholds and pick the next state.
    always_comb begin
        at_hi    = (rx_level >= thr_hi);
        below_lo = (rx_level < thr_lo);
        if (at_hi)         full_nxt = 1'b1;
        else if (below_lo) full_nxt = 1'b0;
        else               full_nxt = full_q;
    end

    // Hold the nearly-full state.
    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= 1'b0;
        else        full_q <= full_nxt;
    end

    assert_set_at_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= thr_hi) |=> full_q);
    assert_clear_below_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level < thr_lo && rx_level < thr_hi) |=> !full_q);
    assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= thr_lo && rx_level < thr_hi) |=> $stable(full_q));
endmodule

// File: rtl/mflow_gate.sv
// Module: transmit permit. Combines the synchronized, active-low modem inputs
// with their enables and updates the permit only at character boundaries.
// Assumes tx_idle is high whenever no character is being shifted.
module mflow_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_cts,
    input  logic auto_dsr,
    input  logic cts_n_s,
    input  logic dsr_n_s,
    input  logic tx_idle,
    output logic tx_permit
);
    logic halt;

    // Far end not ready on any enabled line.
    always_comb halt = (auto_cts & cts_n_s) | (auto_dsr & dsr_n_s);

    // Update the permit only between characters.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_permit <= 1'b1;
        else if (tx_idle) tx_permit <= ~halt;
    end

    assert_hold_mid_char_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle |=> $stable(tx_permit));
    assert_ungated_permits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !auto_cts && !auto_dsr) |=> tx_permit);
endmodule

// File: rtl/mflow_pins.sv
// Module: registered drivers for the request-to-send and terminal-ready pins.
// Selects automatic threshold control, RS485 driver-enable or software bits.
// Assumes all pin outputs are active low.
module mflow_pins
    import mflow_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  mflow_mode_t mode,
    input  logic        full_nxt,
    input  logic        sw_rts,
    input  logic        sw_dtr,
    input  logic        tx_empty,
    output logic        rts_n,
    output logic        dtr_n
);
    logic rts_n_nxt, dtr_n_nxt;

    // Choose each pin's source; RS485 outranks threshold control for dtr_n.
    always_comb begin
        rts_n_nxt = mode.auto_rts ? full_nxt : ~sw_rts;
        if (mode.rs485)         dtr_n_nxt = tx_empty;
        else if (mode.auto_dtr) dtr_n_nxt = full_nxt;
        else                    dtr_n_nxt = ~sw_dtr;
    end

    // Register the pins so they never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_n <= 1'b1;
            dtr_n <= 1'b1;
        end else begin
            rts_n <= rts_n_nxt;
            dtr_n <= dtr_n_nxt;
        end
    end

    assert_rs485_tracks_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode.rs485 |=> (dtr_n == $past(tx_empty)));
    assert_manual_rts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.auto_rts |=> (rts_n == !$past(sw_rts)));
endmodule

// File: rtl/uart_mflow_ctrl.sv
// Module: top of the UART modem-line flow controller. Ties together the
// input synchronizer, receive hysteresis, pin drivers and transmit gate.
// Assumes rx_level never exceeds the FIFO depth.
module uart_mflow_ctrl
    import mflow_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    input  logic             auto_rts_en,
    input  logic             auto_dtr_en,
    input  logic             auto_cts_en,
    input  logic             auto_dsr_en,
    input  logic             rs485_en,
    input  logic             sw_rts,
    input  logic             sw_dtr,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             tx_idle,
    input  logic             tx_empty,
    output logic             rts_n,
    output logic             dtr_n,
    output logic             tx_permit
);
    localparam int unsigned N_MODEM_IN = 2;

    mflow_mode_t           mode;
    logic [N_MODEM_IN-1:0] modem_s;
    logic                  full_nxt, full_q;

    // Bundle the enable bits.
    always_comb begin
        mode.auto_rts = auto_rts_en;
        mode.auto_dtr = auto_dtr_en;
        mode.auto_cts = auto_cts_en;
        mode.auto_dsr = auto_dsr_en;
        mode.rs485    = rs485_en;
    end

    mflow_sync #(.WIDTH(N_MODEM_IN), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk (clk), .rst_n (rst_n),
        .din ({dsr_n, cts_n}), .dout (modem_s)
    );

    mflow_hyst #(.LVL_W(LVL_W)) u_hyst (
        .clk (clk), .rst_n (rst_n),
        .rx_level (rx_level), .thr_hi (thr_hi), .thr_lo (thr_lo),
        .full_nxt (full_nxt), .full_q (full_q)
    );

    mflow_pins u_pins (
        .clk (clk), .rst_n (rst_n), .mode (mode), .full_nxt (full_nxt),
        .sw_rts (sw_rts), .sw_dtr (sw_dtr), .tx_empty (tx_empty),
        .rts_n (rts_n), .dtr_n (dtr_n)
    );

    mflow_gate u_gate (
        .clk (clk), .rst_n (rst_n),
        .auto_cts (mode.auto_cts), .auto_dsr (mode.auto_dsr),
        .cts_n_s (modem_s[0]), .dsr_n_s (modem_s[1]),
        .tx_idle (tx_idle), .tx_permit (tx_permit)
    );

    assert_auto_rts_follows_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && !rs485_en && auto_dtr_en) |=> (rts_n == dtr_n));
endmodule

// File: tb/sim_uart_mflow_ctrl.sv
// Bench: directed scenarios, one task each; drives on falling edges.
module sim_uart_mflow_ctrl;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] rx_level, thr_hi, thr_lo;
    logic       auto_rts_en, auto_dtr_en, auto_cts_en, auto_dsr_en, rs485_en;
    logic       sw_rts, sw_dtr, cts_n, dsr_n, tx_idle, tx_empty;
    logic       rts_n, dtr_n, tx_permit;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    uart_mflow_ctrl u0 (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        rx_level = 0; thr_hi = 8'd96; thr_lo = 8'd32;
        auto_rts_en = 0; auto_dtr_en = 0; auto_cts_en = 0; auto_dsr_en = 0; rs485_en = 0;
        sw_rts = 0; sw_dtr = 0; cts_n = 0; dsr_n = 0; tx_idle = 1; tx_empty = 1;
        tick(3);
        chk("R1 rts_n", rts_n, 1'b1);
        chk("R1 dtr_n", dtr_n, 1'b1);
        chk("R1 tx_permit", tx_permit, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic t_rts_hyst;
        auto_rts_en = 1; rx_level = 8'd50; tick(1);
        chk("R4 mid level keeps ready", rts_n, 1'b0);
        rx_level = 8'd96; tick(1);
        chk("R2 at upper", rts_n, 1'b1);
        rx_level = 8'd95; tick(1);
        chk("R4 just below upper", rts_n, 1'b1);
        rx_level = 8'd32; tick(1);
        chk("R4 at lower", rts_n, 1'b1);
        rx_level = 8'd31; tick(1);
        chk("R3 below lower", rts_n, 1'b0);
        rx_level = 8'd128; tick(1);
        chk("R2 full fifo", rts_n, 1'b1);
        rx_level = 8'd0; tick(1);
        chk("R3 empty fifo", rts_n, 1'b0);
    endtask

    task automatic t_dtr_auto;
        auto_rts_en = 0; auto_dtr_en = 1; sw_rts = 1; rx_level = 8'd100; tick(1);
        chk("R5 dtr full", dtr_n, 1'b1);
        chk("R7 rts from sw", rts_n, 1'b0);
        rx_level = 8'd10; tick(1);
        chk("R5 dtr drained", dtr_n, 1'b0);
    endtask

    task automatic t_manual;
        auto_dtr_en = 0; sw_rts = 0; sw_dtr = 1; rx_level = 8'd120; tick(1);
        chk("R7 rts manual", rts_n, 1'b1);
        chk("R7 dtr manual", dtr_n, 1'b0);
    endtask

    task automatic t_rs485;
        rs485_en = 1; auto_dtr_en = 1; sw_dtr = 1; tx_empty = 0; tick(1);
        chk("R6 driving", dtr_n, 1'b0);
        tx_empty = 1; tick(1);
        chk("R6 released", dtr_n, 1'b1);
        tx_empty = 0; rx_level = 8'd5; tick(1);
        chk("R6 priority", dtr_n, 1'b0);
        rs485_en = 0; auto_dtr_en = 0; tx_empty = 1;
    endtask

    task automatic t_cts;
        auto_cts_en = 1; tx_idle = 1; cts_n = 0; tick(3);
        chk("R8 ready", tx_permit, 1'b1);
        cts_n = 1; tick(2);
        chk("R10 not yet", tx_permit, 1'b1);
        tick(1);
        chk("R10 third edge", tx_permit, 1'b0);
        tx_idle = 0; cts_n = 0; tick(4);
        chk("R8 held mid char", tx_permit, 1'b0);
        tx_idle = 1; tick(1);
        chk("R8 boundary resume", tx_permit, 1'b1);
        tx_idle = 0; cts_n = 1; tick(4);
        chk("R8 keeps sending", tx_permit, 1'b1);
        tx_idle = 1; tick(1);
        chk("R8 stop at boundary", tx_permit, 1'b0);
        cts_n = 0; auto_cts_en = 0; tick(3);
    endtask

    task automatic t_dsr;
        auto_dsr_en = 1; dsr_n = 1; tick(3);
        chk("R9 dsr stop", tx_permit, 1'b0);
        dsr_n = 0; tick(3);
        chk("R9 dsr go", tx_permit, 1'b1);
        auto_dsr_en = 0;
    endtask

    task automatic t_ignore;
        cts_n = 1; dsr_n = 1; tick(4);
        chk("R11 ignored", tx_permit, 1'b1);
        tx_idle = 0; tick(2); tx_idle = 1; tick(1);
        chk("R11 ignored after char", tx_permit, 1'b1);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(1);
        t_reset();
        t_rts_hyst();
        t_dtr_auto();
        t_manual();
        t_rs485();
        t_cts();
        t_dsr();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule